// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address presented to the array of a synchronous pipelined memory. On every enabled rising clock edge it takes one of two actions. It can capture a fresh external address. It can instead step the low two bits of the address it already holds through a four-beat burst. A single control pin selects between the two: low means load, high means advance. A load taken while the chip is deselected closes the current burst instead of starting a new one.

The burst ordering is chosen by a static pin, which the system sets once and leaves alone. In linear order the low bits count upward and wrap modulo four. In interleaved order the low bits are the starting value XORed with the beat number. The upper address bits stay fixed for the whole burst. When the stall pin is high, the edge is treated as though it never happened. All control pins are plain levels sampled at the edge. The block has no streaming interface, so it has no valid/ready handshake.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `cur_addr` is all zeros and `burst_on` is 0.
- R2: On an edge with `stall`=0, `advance`=0 and `sel`=1, `cur_addr` takes the value of `ext_addr` and `burst_on` becomes 1, both visible after that edge.
- R3: On an edge with `stall`=0, `advance`=1 and `burst_on`=1, bits [ADDR_W-1:2] of `cur_addr` do not change, `ext_addr` has no effect, and `burst_on` stays 1.
- R4: With `order_xor`=0 (linear order), the low two bits after the k-th advance are (start + k) mod 4, where start is the low two bits captured at load.
- R5: With `order_xor`=1 (interleaved order), the low two bits after the k-th advance (k = 0..3) are start XOR k.
- R6: The fourth advance after a load brings the low bits back to the starting value in both orders, and the burst keeps cycling after that.
- R7: On an edge with `stall`=0, `advance`=0 and `sel`=0, `burst_on` becomes 0 and `cur_addr` keeps its value.
- R8: On an edge with `stall`=0, `advance`=1 and `burst_on`=0, `cur_addr` is unchanged and `burst_on` stays 0.
- R9: On an edge with `stall`=1, `cur_addr` and `burst_on` keep their values, whatever the other inputs are.
- R10: During an advance, `sel` has no effect. The burst steps whether `sel` is high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | High: the edge is ignored completely |
| sel | input | 1 | Chip selected, already decoded, active high |
| advance | input | 1 | 0 = load or deselect, 1 = step the burst |
| order_xor | input | 1 | Static burst order: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External word address, used only on a load |
| cur_addr | output | ADDR_W | Current array address |
| burst_on | output | 1 | A burst is active |

## Verification
The bench builds the block with its default parameters: an 18-bit address and a 2-bit beat field. With these values every one of the four starting offsets can be reached under both orderings, and each complete wrap takes only five edges. As a result, the full reference table of eight bursts is covered exhaustively. A distinct upper-address pattern is used for each burst, so any corruption of the fixed bits shows up in the output. Stalls, deselect-loads and garbage on the address pins are placed in the middle of bursts.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [2:0] {
    CMD_HOLD,
    CMD_LOAD,
    CMD_END,
    CMD_STEP,
    CMD_IDLE
  } seq_cmd_e;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } seq_order_e;

endpackage

// File: rtl/burst_seq_decode.sv
module burst_seq_decode
  import burst_seq_pkg::*;
(
  input  logic     stall,
  input  logic     advance,
  input  logic     sel,
  input  logic     burst_on,
  output seq_cmd_e cmd
);

  always_comb begin
    if (stall) begin
      cmd = CMD_HOLD;
    end else if (!advance) begin
      cmd = sel ? CMD_LOAD : CMD_END;
    end else begin
      cmd = burst_on ? CMD_STEP : CMD_IDLE;
    end
  end

endmodule

// File: rtl/burst_seq_beat.sv
module burst_seq_beat
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_cmd_e          cmd,
  output logic [BEAT_W-1:0] beat,
  output logic              active
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat   <= '0;
      active <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          beat   <= '0;
          active <= 1'b1;
        end
        CMD_END:  active <= 1'b0;
        CMD_STEP: beat   <= beat + BEAT_W'(1);
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/burst_seq_lowmap.sv
module burst_seq_lowmap
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  seq_order_e        order,
  output logic [BEAT_W-1:0] low
);

  logic [BEAT_W-1:0] lin_v;
  logic [BEAT_W-1:0] xor_v;

  assign lin_v = start + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_v[b] = start[b] ^ beat[b];
  end

  assign low = (order == ORD_XOR) ? xor_v : lin_v;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              sel,
  input  logic              advance,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              burst_on
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  seq_cmd_e          cmd;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;
  seq_order_e        order;

  assign order = seq_order_e'(order_xor);

  burst_seq_decode u_dec (
    .stall    (stall),
    .advance  (advance),
    .sel      (sel),
    .burst_on (burst_on),
    .cmd      (cmd)
  );

  burst_seq_beat #(.BEAT_W(BEAT_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .beat   (beat),
    .active (burst_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (cmd == CMD_LOAD) begin
      base_q <= ext_addr;
    end
  end

  burst_seq_lowmap #(.BEAT_W(BEAT_W)) u_map (
    .start (base_q[BEAT_W-1:0]),
    .beat  (beat),
    .order (order),
    .low   (low)
  );

  assign cur_addr = {base_q[ADDR_W-1 -: UPPER_W], low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              sel,
  input logic              advance,
  input logic              order_xor,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              burst_on
);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(cur_addr) && $stable(burst_on)));

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !advance && sel) |=> (cur_addr == $past(ext_addr) && burst_on));

  assert_deselect_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !advance && !sel) |=> (!burst_on && $stable(cur_addr)));

  assert_idle_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && advance && !burst_on) |=> (!burst_on && $stable(cur_addr)));

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && advance && burst_on) |=>
      (burst_on && $stable(cur_addr[ADDR_W-1:BEAT_W])));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && advance && burst_on && !order_xor) |=>
      (cur_addr[BEAT_W-1:0] == $past(cur_addr[BEAT_W-1:0]) + BEAT_W'(1)));

  assert_xor_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && advance && burst_on && order_xor) |=>
      (cur_addr[BEAT_W-1:0] != $past(cur_addr[BEAT_W-1:0])));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .sel       (sel),
  .advance   (advance),
  .order_xor (order_xor),
  .ext_addr  (ext_addr),
  .cur_addr  (cur_addr),
  .burst_on  (burst_on)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic          sel = 1'b0;
  logic          advance = 1'b0;
  logic          order_xor = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;
  logic          burst_on;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sel(sel), .advance(advance),
    .order_xor(order_xor), .ext_addr(ext_addr), .cur_addr(cur_addr),
    .burst_on(burst_on)
  );

  // {order, start, low after load, after advance 1..4}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b0, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b0, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b1, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1},
    {1'b1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b1, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0, 2'd3}
  };

  task automatic tick(input logic adv, input logic s, input logic st,
                      input logic [AW-1:0] a);
    @(negedge clk);
    advance  = adv;
    sel      = s;
    stall    = st;
    ext_addr = a;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    stall = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #2;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check(input string tag, input logic [AW-1:0] exp_a,
                       input logic exp_on);
    checks++;
    if (cur_addr !== exp_a || burst_on !== exp_on) begin
      errors++;
      $display("FAIL %s: cur_addr=%h burst_on=%b expected cur_addr=%h burst_on=%b",
               tag, cur_addr, burst_on, exp_a, exp_on);
    end
  endtask

  initial begin
    logic [AW-1:0] held;
    do_reset();
    check("R1 reset state", '0, 1'b0);
    release_reset();

    // Reference table walk
    for (int i = 0; i < 8; i++) begin
      logic [AW-3:0] upper;
      logic [1:0]    start;
      logic          ord;
      string         rq;
      ord   = VEC[i][12];
      start = VEC[i][11:10];
      upper = (AW-2)'(i * 16'h2E5B + 16'h0101);
      rq    = ord ? "R5 interleaved" : "R4 linear";
      if (i == 0 || i == 4) begin
        do_reset();
        order_xor = ord;
        release_reset();
      end
      tick(1'b0, 1'b1, 1'b0, {upper, start});
      check({rq, " R2 load"}, {upper, VEC[i][9:8]}, 1'b1);
      tick(1'b1, 1'b1, 1'b0, ~{upper, start});
      check({rq, " R3 beat1"}, {upper, VEC[i][7:6]}, 1'b1);
      tick(1'b1, 1'b0, 1'b0, {upper, start} ^ 18'h15555);
      check({rq, " R10 beat2 sel low"}, {upper, VEC[i][5:4]}, 1'b1);
      tick(1'b0, 1'b0, 1'b1, '0);
      check({rq, " R9 stall mid-burst"}, {upper, VEC[i][5:4]}, 1'b1);
      tick(1'b1, 1'b1, 1'b0, '1);
      check({rq, " beat3"}, {upper, VEC[i][3:2]}, 1'b1);
      tick(1'b1, 1'b1, 1'b0, '0);
      check({rq, " R6 wrap to start"}, {upper, VEC[i][1:0]}, 1'b1);
    end

    // Deselect-load ends burst, later advances do nothing
    order_xor = 1'b0;
    tick(1'b0, 1'b1, 1'b0, 18'h2A5A1);
    tick(1'b1, 1'b1, 1'b0, '0);
    check("R4 step before deselect", 18'h2A5A2, 1'b1);
    tick(1'b0, 1'b0, 1'b0, 18'h3FFFF);
    check("R7 deselect ends burst", 18'h2A5A2, 1'b0);
    tick(1'b1, 1'b1, 1'b0, 18'h11111);
    check("R8 idle advance 1", 18'h2A5A2, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 18'h22222);
    check("R8 idle advance 2", 18'h2A5A2, 1'b0);

    // Stall while idle with a would-be load
    tick(1'b0, 1'b1, 1'b1, 18'h0F0F3);
    check("R9 stall blocks load", 18'h2A5A2, 1'b0);
    held = 18'h0F0F3;
    tick(1'b0, 1'b1, 1'b0, held);
    check("R2 load after stall", held, 1'b1);

    // Reset mid-burst
    tick(1'b1, 1'b1, 1'b0, '0);
    do_reset();
    check("R1 reset mid-burst", '0, 1'b0);
    release_reset();
    tick(1'b1, 1'b1, 1'b0, 18'h12345);
    check("R8 advance after reset", '0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule